// File: doc/BRIEF.md
# Single-Subcarrier Card Response Symbol Encoder

This block turns a byte stream into the symbol sequence a vicinity card sends back to a reader when it answers on one subcarrier. Each output symbol stands for one slot of 8 subcarrier pulses at fc/32, roughly 18.88 µs long. A symbol of 1 means the pulses are present in that slot and a symbol of 0 means the slot stays unmodulated. A frame has three parts in this order: a fixed start group, the Manchester-coded data, and a fixed end group. A downstream modulator gates the subcarrier with `sym_out`. That modulator also supplies `sym_tick`, a one-cycle strobe that moves the stream on by one symbol.

Bytes enter through a valid/ready port that carries a last flag. A one-byte holding register sits behind `in_ready`, so the next byte can be accepted while the current one is still being sent. Back-pressure follows these rules:
- `in_ready` drops in the cycle after every acceptance and stays low until the held byte is taken into the coder.
- Once a byte flagged last has been accepted, `in_ready` stays low until the frame has finished.
- If the holding register is empty when the coder needs a byte, it fills each strobe with an unmodulated symbol until a byte arrives. No data is lost.

Top module: `resp_manchester_enc`

## Requirements
- R1: A frame starts when a byte is accepted while the encoder is idle. The first strobe after the accepting clock edge emits the first symbol of the start group 00011101. Symbols are emitted most significant first, one per strobe.
- R2: Each data bit becomes two symbols. A 1 becomes 0 then 1 (quiet slot, then pulses). A 0 becomes 1 then 0 (pulses, then quiet slot).
- R3: Bits are sent least significant first, so the low nibble of a byte goes out before the high nibble. A nibble of 0x0 forms the 8-symbol group 0xAA and a nibble of 0xF forms 0x55.
- R4: After both groups of the byte flagged last, the end group 10111000 is emitted most significant first.
- R5: `sym_out` changes only on a clock edge at which `sym_tick` is high. Between strobes it holds its value.
- R6: While idle, `sym_out` is 0. Strobes with no accepted byte start nothing and leave `done` low.
- R7: `done` is high for exactly one cycle. It rises after the strobe that follows the final end-group symbol, and at that strobe `sym_out` returns to 0.
- R8: `in_ready` is low in the cycle after each acceptance. After the last-flagged byte is accepted it stays low until `done`, and it is high again in the cycle after `done`.
- R9: If no byte is held when a data group must start, every such strobe emits 0. The byte's groups begin at the first strobe after that byte has been accepted.
- R10: After reset, `sym_out` and `done` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | One-cycle strobe that advances the stream by one symbol |
| in_valid | input | 1 | Byte offer valid |
| in_data | input | DATA_W | Byte to encode |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Holding register can take a byte |
| sym_out | output | 1 | Current symbol: 1 = pulses present, 0 = unmodulated |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
The checker assumes that `sym_tick` is a strobe the encoder never stalls, and that an offered byte keeps `in_valid`, `in_data` and `in_last` stable until it is accepted. Ordering of the symbols is left to the bench; the checker only relates acceptance, holding, idle level and the single-cycle completion pulse.

The bench holds every offer until the handshake completes. It schedules the first strobe of a frame two cycles after offering the first byte, so that strobe can never land on the accepting edge. In the underrun case it spaces strobes three cycles apart, which lets a late byte be accepted strictly between two strobes.

// File: rtl/resp_enc_pkg.sv
package resp_enc_pkg;
  // Which group the sequencer loads at the next strobe once the shifter is empty.
  typedef enum logic [1:0] {
    PH_SOF = 2'd0,
    PH_NIB = 2'd1,
    PH_EOF = 2'd2,
    PH_FIN = 2'd3
  } phase_e;
endpackage

// File: rtl/resp_byte_hold.sv
module resp_byte_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              accept,
  input  logic              take,
  input  logic              frame_end,
  output logic              held_full,
  output logic [DATA_W-1:0] held_data,
  output logic              held_last
);
  logic full_q;
  logic lock_q;
  logic last_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !full_q && !lock_q;
  assign accept    = in_valid && in_ready;
  assign held_full = full_q;
  assign held_data = data_q;
  assign held_last = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      lock_q <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= in_data;
        last_q <= in_last;
      end else if (take) begin
        full_q <= 1'b0;
      end
      // once the closing byte is in, nothing more enters until the frame ends
      if (accept && in_last) lock_q <= 1'b1;
      else if (frame_end)    lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_group_coder.sv
module resp_group_coder #(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 8,
  parameter int IDX_W  = 1
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  sel,
  output logic [GRP_W-1:0]  code
);
  localparam int HALF = GRP_W / 2;

  logic [HALF-1:0] chunk;
  assign chunk = word[int'(sel)*HALF +: HALF];

  // bit b of the chunk lands at pair b counted from the top: first on air
  for (genvar b = 0; b < HALF; b++) begin : g_pair
    assign code[GRP_W-1-2*b -: 2] = chunk[b] ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/resp_symbol_shifter.sv
module resp_symbol_shifter #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [GRP_W-1:0] load_grp,
  output logic             sym_out,
  output logic             empty
);
  localparam int CNT_W = $clog2(GRP_W + 1);

  logic [GRP_W-1:0] sr_q;
  logic [CNT_W-1:0] left_q;
  logic             sym_q;

  assign sym_out = sym_q;
  assign empty   = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      sym_q  <= 1'b0;
    end else if (tick) begin
      if (load) begin
        sym_q  <= load_grp[GRP_W-1];
        sr_q   <= load_grp << 1;
        left_q <= CNT_W'(GRP_W - 1);
      end else if (left_q != '0) begin
        sym_q  <= sr_q[GRP_W-1];
        sr_q   <= sr_q << 1;
        left_q <= left_q - 1'b1;
      end else begin
        sym_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/resp_manchester_enc.sv
module resp_manchester_enc
  import resp_enc_pkg::*;
#(
  parameter int             DATA_W  = 8,
  parameter int             GRP_W   = 8,
  parameter logic [GRP_W-1:0] SOF_PAT = 8'b0001_1101,
  parameter logic [GRP_W-1:0] EOF_PAT = 8'b1011_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              sym_out,
  output logic              done
);
  localparam int BITS_PER_GRP = GRP_W / 2;
  localparam int GRPS         = DATA_W / BITS_PER_GRP;
  localparam int IDX_W        = (GRPS > 1) ? $clog2(GRPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRPS - 1);

  logic              accept, take, frame_end;
  logic              held_full, held_last;
  logic [DATA_W-1:0] held_data;
  logic              load, grp_empty, step;
  logic [GRP_W-1:0]  load_grp, coded;
  logic [DATA_W-1:0] code_word;
  logic              cur_last;

  phase_e            phase_q;
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  nib_q;
  logic [DATA_W-1:0] stash_q;
  logic              stash_last_q;

  resp_byte_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .accept    (accept),
    .take      (take),
    .frame_end (frame_end),
    .held_full (held_full),
    .held_data (held_data),
    .held_last (held_last)
  );

  // group 0 of a byte codes straight from the holding register
  assign code_word = (nib_q == '0) ? held_data : stash_q;
  assign cur_last  = (nib_q == '0) ? held_last : stash_last_q;

  resp_group_coder #(.DATA_W(DATA_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_coder (
    .word (code_word),
    .sel  (nib_q),
    .code (coded)
  );

  resp_symbol_shifter #(.GRP_W(GRP_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sym_tick),
    .load     (load),
    .load_grp (load_grp),
    .sym_out  (sym_out),
    .empty    (grp_empty)
  );

  assign step = sym_tick && busy_q && grp_empty;
  assign done = done_q;

  always_comb begin
    load      = 1'b0;
    take      = 1'b0;
    frame_end = 1'b0;
    load_grp  = coded;
    unique case (phase_q)
      PH_SOF: begin
        load     = step;
        load_grp = SOF_PAT;
      end
      PH_NIB: begin
        if (nib_q == '0) begin
          load = step && held_full;
          take = load;
        end else begin
          load = step;
        end
      end
      PH_EOF: begin
        load     = step;
        load_grp = EOF_PAT;
      end
      PH_FIN: frame_end = step;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_SOF;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      nib_q        <= '0;
      stash_q      <= '0;
      stash_last_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (accept) begin
          busy_q  <= 1'b1;
          phase_q <= PH_SOF;
          nib_q   <= '0;
        end
      end else if (step) begin
        unique case (phase_q)
          PH_SOF: begin
            phase_q <= PH_NIB;
            nib_q   <= '0;
          end
          PH_NIB: begin
            if (load) begin
              if (nib_q == '0) begin
                stash_q      <= held_data;
                stash_last_q <= held_last;
              end
              if (nib_q == LAST_IDX) begin
                nib_q   <= '0;
                phase_q <= cur_last ? PH_EOF : PH_NIB;
              end else begin
                nib_q <= nib_q + 1'b1;
              end
            end
          end
          PH_EOF: phase_q <= PH_FIN;
          PH_FIN: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/resp_enc_checker.sv
module resp_enc_checker (
  input logic clk,
  input logic rst_n,
  input logic sym_tick,
  input logic in_valid,
  input logic in_ready,
  input logic sym_out,
  input logic done,
  input logic busy
);
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sym_out);

  assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_tick |=> $stable(sym_out));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sym_out && !busy));

  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind resp_manchester_enc resp_enc_checker u_resp_enc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_tick (sym_tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sym_out  (sym_out),
  .done     (done),
  .busy     (busy_q)
);

// File: tb/test_resp_manchester_enc.sv
`timescale 1ns/1ps
module test_resp_manchester_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready, sym_out, done;

  int checks = 0;
  int fails  = 0;

  logic [7:0] frame_b [0:15];
  logic       exp_sym [0:511];
  int         exp_tag [0:511];
  int         exp_n;

  always #2.5 clk = ~clk;

  resp_manchester_enc i_resp_manchester_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_tick (sym_tick),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .sym_out  (sym_out),
    .done     (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagname(input int t);
    case (t)
      1:       return "R1 start group symbol";
      2:       return "R2 R3 data symbol";
      3:       return "R4 end group symbol";
      default: return "R9 underrun filler";
    endcase
  endfunction

  task automatic push(input logic s, input int t);
    exp_sym[exp_n] = s;
    exp_tag[exp_n] = t;
    exp_n++;
  endtask

  // expected symbols straight from the requirements
  task automatic build_expected(input int n, input int gap_k, input int gap_len);
    logic [7:0] sof = 8'b0001_1101;
    logic [7:0] eof = 8'b1011_1000;
    exp_n = 0;
    for (int i = 7; i >= 0; i--) push(sof[i], 1);
    for (int k = 0; k < n; k++) begin
      if (k == gap_k) for (int g = 0; g < gap_len; g++) push(1'b0, 4);
      for (int i = 0; i < 8; i++) begin
        push(!frame_b[k][i], 2);
        push(frame_b[k][i], 2);
      end
    end
    for (int i = 7; i >= 0; i--) push(eof[i], 3);
  endtask

  task automatic run_frame(input int n, input int fixed_idle, input int rel_k,
                           input int rel_tick, input int gap_len);
    int  idx = 0;
    int  tick_no = 0;
    int  sent = 0;
    int  cd = 2;
    int  cyc = 0;
    bit  fin = 0;
    bit  tick_prev = 0;
    bit  rdy = 0;
    logic sym_prev = 1'b0;
    build_expected(n, rel_k, gap_len);
    while (!fin && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (in_valid && rdy) begin
        sent++;
        chk("R8 ready low after acceptance", int'(in_ready), 0);
      end
      if (tick_prev) begin
        tick_no++;
        if (idx < exp_n) begin
          chk(tagname(exp_tag[idx]), int'(sym_out), int'(exp_sym[idx]));
          chk("R7 no early done", int'(done), 0);
          idx++;
        end else begin
          chk("R7 done pulse", int'(done), 1);
          chk("R7 output low at done", int'(sym_out), 0);
          fin = 1;
        end
        if (sent == n && !fin) chk("R8 ready held low after last byte", int'(in_ready), 0);
      end else begin
        chk("R5 hold between strobes", int'(sym_out), int'(sym_prev));
        chk("R7 done only on strobe", int'(done), 0);
      end
      sym_prev = sym_out;
      if (fin) begin
        sym_tick = 1'b0;
        in_valid = 1'b0;
      end else begin
        if (cd == 0) begin
          sym_tick = 1'b1;
          cd = (fixed_idle >= 0) ? fixed_idle : int'($urandom_range(0, 3));
        end else begin
          sym_tick = 1'b0;
          cd--;
        end
        if (sent < n && (sent != rel_k || tick_no >= rel_tick)) begin
          in_valid = 1'b1;
          in_data  = frame_b[sent];
          in_last  = (sent == n - 1);
        end else begin
          in_valid = 1'b0;
          in_data  = 8'($urandom);
          in_last  = 1'($urandom);
        end
      end
      tick_prev = sym_tick;
      rdy = in_ready;
    end
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7: frame did not end, actual 0 expected 1");
    end
    @(negedge clk);
    chk("R8 ready back after done", int'(in_ready), 1);
    chk("R7 done single cycle", int'(done), 0);
  endtask

  task automatic idle_ticks(input int cnt);
    in_valid = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      sym_tick = (i % 2 == 0);
      @(negedge clk);
      sym_tick = 1'b0;
      chk("R6 idle output low", int'(sym_out), 0);
      chk("R6 idle no done", int'(done), 0);
      chk("R6 idle ready", int'(in_ready), 1);
    end
  endtask

  initial begin
    #(190000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10 reset output", int'(sym_out), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", int'(in_ready), 1);

    idle_ticks(6);

    // R3 nibble 0 -> 0xAA groups
    frame_b[0] = 8'h00;
    run_frame(1, 1, -1, 0, 0);
    // R3 nibble F -> 0x55 groups
    frame_b[0] = 8'hFF;
    run_frame(1, 0, -1, 0, 0);
    // R2 mixed bits, strobe every cycle
    frame_b[0] = 8'h01; frame_b[1] = 8'h80; frame_b[2] = 8'hA5;
    run_frame(3, 0, -1, 0, 0);
    // R9 second byte withheld past its slot: strobes 25..27 are filler
    frame_b[0] = 8'h3C; frame_b[1] = 8'hC3; frame_b[2] = 8'h96;
    run_frame(3, 2, 1, 27, 3);

    idle_ticks(4);

    for (int f = 0; f < 24; f++) begin
      int n = int'($urandom_range(1, 6));
      for (int k = 0; k < n; k++) frame_b[k] = 8'($urandom);
      run_frame(n, -1, -1, 0, 0);
    end

    idle_ticks(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule